// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialisation Sequencer

This block brings a DDR SDRAM device from power-on to a usable state. After reset it holds the clock-enable pin low while supply and clock settle. It then raises clock enable and issues a fixed train of commands on the chip-select, row-strobe, column-strobe, write-enable, bank-address and address pins. The train is: a precharge of every bank, a load of the extended mode register, and a load of the mode register that resets the DLL. These are followed by a second all-bank precharge, a configurable number of auto-refresh commands, and a final mode register load with the DLL reset bit cleared.

Every wait is a cycle count derived at elaboration time. Each count is the ceiling of a time parameter divided by the clock period parameter, and one shared down-counter times all of them. Between commands the pins show deselect.

The block gives two qualifications. `cmd_ready` goes high once the sequence has finished, and from then on any non-read command may be issued. `init_done` goes high once, in addition, a fixed number of clock cycles has passed since the DLL-reset load, so that reads are safe. The mode and extended-mode opcodes arrive as static inputs. The block forces the DLL reset bit itself in both mode register loads.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held, and for the first ceil(T_STAB_PS/CLK_PERIOD_PS) cycles after it is released, `cke` is 0 and `cs_n` is 1.
- R2: `cke` rises in cycle STAB, where cycle k is the k-th cycle after reset release, counting from 0. It stays 1 from then on. Cycle STAB carries no command.
- R3: The first command is an all-bank precharge in cycle STAB+1. Its pins are cs_n=0, ras_n=0, cas_n=1, we_n=0, with address bit 10 high, all other address bits 0, and bank 0.
- R4: The second command loads the extended mode register. Its pins are cs_n, ras_n, cas_n and we_n all 0, with bank address 1 and address equal to `emr_code`.
- R5: The third command loads the mode register with bank address 0 and address equal to `mr_code` with bit 8 forced to 1, whatever the value of `mr_code` bit 8.
- R6: Next come a second all-bank precharge, encoded as in R3, and then exactly N_REF auto-refresh commands. Each refresh has cs_n=0, ras_n=0, cas_n=0, we_n=1, with address and bank 0.
- R7: The last command loads the mode register with bank address 0 and address equal to `mr_code` with bit 8 forced to 0.
- R8: Only the commands of R3 to R7 are ever issued, in that order. In every other cycle `cs_n`, `ras_n`, `cas_n` and `we_n` are all 1.
- R9: `cmd_ready` is 0 until MRD cycles after the final mode register load, then 1 and held.
- R10: `init_done` rises in the later of two cycles: the cycle in which `cmd_ready` rises, and DLL_LOCK_CYC cycles after the DLL-reset load. Once high it stays high.
- R11: After a precharge, exactly ceil(tRP/period) deselect cycles pass before the next command. After a register load the count is ceil(tMRD/period), and after a refresh it is ceil(tRFC/period), each count being at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| emr_code | input | ADDR_W | Opcode placed on the address pins for the extended mode register load |
| mr_code | input | ADDR_W | Opcode for both mode register loads; bit 8 is overridden |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address / opcode bus |
| cmd_ready | output | 1 | Non-read commands permitted |
| init_done | output | 1 | All commands, including reads, permitted |

## Verification
The sequence is run twice, from two resets, with different opcode pairs. In the first run `mr_code` bit 8 is clear, so only the forcing in the first load is visible. In the second run it is set, so only the clearing in the final load is visible. The two extended-mode codes also differ, which separates the opcode path from constant values. With the default timing, the MRD wait is one cycle while the RP and RFC waits are longer. This tells an off-by-one in the shared counter apart from a wrong wait selection. Because the DLL-lock count outlasts the sequence, `init_done` visibly lags `cmd_ready`.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_STAB, ST_CKE,
    ST_PRE1, ST_WPRE1,
    ST_EMRS, ST_WEMRS,
    ST_MRSD, ST_WMRSD,
    ST_PRE2, ST_WPRE2,
    ST_REF,  ST_WREF,
    ST_MRS,  ST_WMRS,
    ST_READY
  } init_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_DESEL = cmd_pins_t'(4'b1111);
  localparam cmd_pins_t CMD_PRE   = cmd_pins_t'(4'b0010);
  localparam cmd_pins_t CMD_REF   = cmd_pins_t'(4'b0001);
  localparam cmd_pins_t CMD_LMR   = cmd_pins_t'(4'b0000);

  // ceiling division, never below one cycle
  function automatic int unsigned cyc_ceil(int unsigned t_ps, int unsigned p_ps);
    int unsigned c;
    c = (t_ps + p_ps - 1) / p_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int unsigned TW      = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en  = load || (cnt_q != '0);
  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = load_val;
    else if (!expired)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= TW'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R11
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
  parameter int unsigned LOCK_CYC = 200,
  localparam int unsigned LW = $clog2(LOCK_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic lock_ok
);
  logic [LW-1:0] cnt_q;
  logic          armed_q;

  assign lock_ok = armed_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= LW'(LOCK_CYC - 1);
      armed_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ok && !start) |=> lock_ok);
endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BA_W        = 2,
  parameter int unsigned TW          = 16,
  parameter int unsigned RP_CYC      = 2,
  parameter int unsigned MRD_CYC     = 1,
  parameter int unsigned RFC_CYC     = 8,
  parameter int unsigned N_REF       = 2,
  parameter int unsigned DLL_BIT     = 8,
  parameter int unsigned PREALL_BIT  = 10,
  localparam int unsigned RW = $clog2(N_REF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] emr_code,
  input  logic [ADDR_W-1:0] mr_code,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              dll_start,
  output logic              cke,
  output cmd_pins_t         cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              cmd_ready
);
  localparam logic [TW-1:0]   RP_LD  = TW'(RP_CYC - 1);
  localparam logic [TW-1:0]   MRD_LD = TW'(MRD_CYC - 1);
  localparam logic [TW-1:0]   RFC_LD = TW'(RFC_CYC - 1);
  localparam logic [BA_W-1:0] EMR_BA = BA_W'(1);
  localparam logic [BA_W-1:0] MR_BA  = '0;

  init_state_e   state_q, state_d;
  logic [RW-1:0] ref_q;
  logic          ref_inc;

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_STAB:  if (tmr_expired) state_d = ST_CKE;
      ST_CKE:   state_d = ST_PRE1;
      ST_PRE1:  state_d = ST_WPRE1;
      ST_WPRE1: if (tmr_expired) state_d = ST_EMRS;
      ST_EMRS:  state_d = ST_WEMRS;
      ST_WEMRS: if (tmr_expired) state_d = ST_MRSD;
      ST_MRSD:  state_d = ST_WMRSD;
      ST_WMRSD: if (tmr_expired) state_d = ST_PRE2;
      ST_PRE2:  state_d = ST_WPRE2;
      ST_WPRE2: if (tmr_expired) state_d = ST_REF;
      ST_REF:   state_d = ST_WREF;
      ST_WREF:  if (tmr_expired) state_d = (ref_q == RW'(N_REF)) ? ST_MRS : ST_REF;
      ST_MRS:   state_d = ST_WMRS;
      ST_WMRS:  if (tmr_expired) state_d = ST_READY;
      ST_READY: state_d = ST_READY;
      default:  state_d = ST_STAB;
    endcase
  end

  assign ref_inc = (state_q == ST_REF);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STAB;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ref_inc) ref_q <= ref_q + 1'b1;
    end
  end

  // Moore output decode
  always_comb begin
    cmd      = CMD_DESEL;
    ba       = '0;
    addr     = '0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_PRE1, ST_PRE2: begin
        cmd = CMD_PRE;
        addr[PREALL_BIT] = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = RP_LD;
      end
      ST_EMRS: begin
        cmd = CMD_LMR; ba = EMR_BA; addr = emr_code;
        tmr_load = 1'b1; tmr_val = MRD_LD;
      end
      ST_MRSD: begin
        cmd = CMD_LMR; ba = MR_BA; addr = mr_code;
        addr[DLL_BIT] = 1'b1;
        tmr_load = 1'b1; tmr_val = MRD_LD;
      end
      ST_MRS: begin
        cmd = CMD_LMR; ba = MR_BA; addr = mr_code;
        addr[DLL_BIT] = 1'b0;
        tmr_load = 1'b1; tmr_val = MRD_LD;
      end
      ST_REF: begin
        cmd = CMD_REF;
        tmr_load = 1'b1; tmr_val = RFC_LD;
      end
      default: ;
    endcase
  end

  assign cke       = (state_q != ST_STAB);
  assign dll_start = (state_q == ST_MRSD);
  assign cmd_ready = (state_q == ST_READY);

  // R1
  cke_low_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd.cs_n);
  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  // R11
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.cs_n |=> cmd.cs_n);
  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> (cmd_ready && cmd.cs_n));
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned BA_W          = 2,
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_STAB_PS     = 200000000,
  parameter int unsigned T_RP_PS       = 15000,
  parameter int unsigned T_MRD_PS      = 10000,
  parameter int unsigned T_RFC_PS      = 75000,
  parameter int unsigned N_REF         = 2,
  parameter int unsigned DLL_LOCK_CYC  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] emr_code,
  input  logic [ADDR_W-1:0] mr_code,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              cmd_ready,
  output logic              init_done
);
  localparam int unsigned STAB_CYC = cyc_ceil(T_STAB_PS, CLK_PERIOD_PS);
  localparam int unsigned RP_CYC   = cyc_ceil(T_RP_PS,   CLK_PERIOD_PS);
  localparam int unsigned MRD_CYC  = cyc_ceil(T_MRD_PS,  CLK_PERIOD_PS);
  localparam int unsigned RFC_CYC  = cyc_ceil(T_RFC_PS,  CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC  = umax(umax(STAB_CYC, RP_CYC), umax(MRD_CYC, RFC_CYC));
  localparam int unsigned TW       = $clog2(MAX_CYC + 1);

  logic          tmr_load, tmr_expired, dll_start, lock_ok;
  logic [TW-1:0] tmr_val;
  cmd_pins_t     cmd;

  ddr_init_timer #(.TW(TW), .RST_VAL(STAB_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  ddr_init_lock #(.LOCK_CYC(DLL_LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(dll_start), .lock_ok(lock_ok)
  );

  ddr_init_fsm #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .TW(TW),
    .RP_CYC(RP_CYC), .MRD_CYC(MRD_CYC), .RFC_CYC(RFC_CYC), .N_REF(N_REF)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .emr_code(emr_code), .mr_code(mr_code),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .dll_start(dll_start), .cke(cke), .cmd(cmd), .ba(ba), .addr(addr),
    .cmd_ready(cmd_ready)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign init_done = cmd_ready && lock_ok;

  // R10
  done_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd_ready && cke));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;
  localparam int CLK_PS  = 10000;
  localparam int ADDR_W  = 13;
  localparam int BA_W    = 2;
  localparam int STAB    = 20000;       // 200 us / 10 ns
  localparam int RP      = 2;           // ceil(15 ns / 10 ns)
  localparam int MRD     = 1;           // ceil(10 ns / 10 ns)
  localparam int RFC     = 8;           // ceil(75 ns / 10 ns)
  localparam int NREF    = 2;
  localparam int LOCK    = 200;

  typedef struct {
    int          cyc;
    logic [3:0]  pins;
    logic [1:0]  ba;
    logic [12:0] addr;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] emr_code = '0, mr_code = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, cmd_ready, init_done;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;

  int tests = 0, fails = 0;
  int cyc = 0;
  bit active = 0;
  exp_t exp_q[$];
  int cke_err, desel_err, rdy_err, done_err;
  int cke_rise, rdy_rise, done_rise;
  int exp_ready, exp_done;

  always #(CLK_PS/2 * 1ps) clk = ~clk;

  ddr_init_seq dut (
    .clk(clk), .rst_n(rst_n), .emr_code(emr_code), .mr_code(mr_code),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cmd_ready(cmd_ready), .init_done(init_done)
  );

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // monitor: pops expected commands as the design issues them
  always @(negedge clk) begin
    if (rst_n && active) begin
      if (!cs_n) begin
        if (exp_q.size() == 0) begin
          check(0, "R8", "unexpected command", {cs_n, ras_n, cas_n, we_n}, 4'hf);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.cyc, e.req, "command cycle", cyc, e.cyc);
          check({ras_n, cas_n, we_n, ba, addr} == {e.pins[2:0], e.ba, e.addr},
                e.req, "command pins", {ras_n, cas_n, we_n, ba, addr},
                {e.pins[2:0], e.ba, e.addr});
        end
      end else if ({ras_n, cas_n, we_n} != 3'b111) begin
        desel_err++;
      end
      if ((cyc < STAB) == cke) cke_err++;
      if (cke && cke_rise < 0) cke_rise = cyc;
      if (cmd_ready && rdy_rise < 0) rdy_rise = cyc;
      if (init_done && done_rise < 0) done_rise = cyc;
      if (cmd_ready != (cyc >= exp_ready)) rdy_err++;
      if (init_done != (cyc >= exp_done))  done_err++;
    end
  end

  task automatic push(int c, logic [3:0] p, logic [1:0] b, logic [12:0] a, string r);
    exp_t e;
    e.cyc = c; e.pins = p; e.ba = b; e.addr = a; e.req = r;
    exp_q.push_back(e);
  endtask

  // driver: resets the design and loads the scoreboard for one opcode pair
  task automatic run_seq(logic [12:0] emr, logic [12:0] mr);
    int t, t_dll;
    active = 0;
    @(negedge clk);
    rst_n = 0;
    emr_code = emr;
    mr_code = mr;
    repeat (3) @(negedge clk);
    check(cke == 0 && cs_n == 1 && cmd_ready == 0 && init_done == 0,
          "R1", "reset state", {cke, cs_n, cmd_ready, init_done}, 4'b0100);
    exp_q.delete();
    cke_err = 0; desel_err = 0; rdy_err = 0; done_err = 0;
    cke_rise = -1; rdy_rise = -1; done_rise = -1;
    t = STAB + 1;
    push(t, 4'b0010, 2'd0, 13'h0400, "R3");
    t += RP + 1;
    push(t, 4'b0000, 2'd1, emr, "R4");
    t += MRD + 1;
    t_dll = t;
    push(t, 4'b0000, 2'd0, mr | 13'h0100, "R5");
    t += MRD + 1;
    push(t, 4'b0010, 2'd0, 13'h0400, "R6");
    t += RP + 1;
    for (int i = 0; i < NREF; i++) begin
      push(t, 4'b0001, 2'd0, 13'h0000, "R6");
      t += RFC + 1;
    end
    push(t, 4'b0000, 2'd0, mr & ~13'h0100, "R7");
    exp_ready = t + MRD + 1;
    exp_done  = (exp_ready > t_dll + LOCK) ? exp_ready : t_dll + LOCK;
    active = 1;
    rst_n = 1;
    wait (cyc >= exp_done + 20);
    @(negedge clk);
    active = 0;
    check(exp_q.size() == 0, "R8", "commands left unissued", exp_q.size(), 0);
    check(cke_err == 0, "R1", "cke level errors", cke_err, 0);
    check(cke_rise == STAB, "R2", "cke rise cycle", cke_rise, STAB);
    check(desel_err == 0, "R8", "idle pins not deselect", desel_err, 0);
    check(rdy_rise == exp_ready, "R9", "cmd_ready rise cycle", rdy_rise, exp_ready);
    check(rdy_err == 0, "R9", "cmd_ready level errors", rdy_err, 0);
    check(done_rise == exp_done, "R10", "init_done rise cycle", done_rise, exp_done);
    check(done_err == 0, "R10", "init_done level errors", done_err, 0);
    // R11: command cycles in the queue encode the RP/MRD/RFC gaps
  endtask

  initial begin
    run_seq(13'h0002, 13'h0062);   // mr bit 8 clear: forcing high visible (R5)
    run_seq(13'h0000, 13'h0163);   // mr bit 8 set: clearing visible (R7)
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule